// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block converts a list of scatter-gather segments into a table of region descriptors that a bus-master DMA engine can walk. Each segment is a 32-bit bus address and a byte length. Each descriptor is two 32-bit words: an address word, then a count word whose low 16 bits carry the byte count. The block writes the words through a single-word memory write port into a table of `DEPTH` descriptors. Word addresses start at zero, and each descriptor takes two consecutive word addresses, the address word first.

A pulse on `start_i` with `seg_count_i` loads the number of segments to expect. The segments then arrive on a valid/ready stream. No descriptor may span a 64 KiB address boundary. A chunk of exactly 64 KiB would leave a count field of zero, so it becomes two 32 KiB descriptors instead. When the stream ends, the last count word is rewritten with its top bit set as an end-of-table marker. `done_o` then pulses, and `entry_count_o` reports the number of descriptors. If the table would overflow, or no descriptor results, the block raises `fallback_o` and reports zero. The caller then moves the data by other means.

Top module: `sgprd_builder`

## Requirements
- R1: After reset, `done_o`, `fallback_o`, `mem_we_o` and `seg_ready_o` are 0 and `entry_count_o` is 0.
- R2: Each descriptor's length is the smaller of the segment's remaining length and 0x10000 minus the low 16 bits of the current address. The next descriptor starts at the current address plus that length, so no descriptor crosses a 64 KiB boundary.
- R3: Descriptor k is written as the address word at word address 2k and the count word at 2k+1. Bits 15:0 of the count word hold the length, and bits 30:16 are zero.
- R4: A chunk of exactly 0x10000 bytes is emitted as (addr, 0x8000) followed by (addr+0x8000, 0x8000). No count word has a zero length field.
- R5: A zero-length segment is accepted from the stream and produces no descriptor.
- R6: On success, bit 31 of the count word of the last descriptor is set, and no other count word has bit 31 set.
- R7: If the build needs more than `DEPTH` descriptors, including the extra half of a split chunk, the build aborts with `fallback_o`=1 and `entry_count_o`=0, and no count word with bit 31 set is written.
- R8: If `seg_count_i` is 0, or every segment has zero length, the build ends with `fallback_o`=1 and `entry_count_o`=0 and makes no memory write.
- R9: `done_o` is high for exactly one cycle per build. `entry_count_o` and `fallback_o` keep their values from the done cycle until the next `start_i`.
- R10: `seg_ready_o` is high only while the block waits for a segment, and memory is never written in a cycle with `seg_ready_o` high. A successful build accepts exactly `seg_count_i` segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a build (taken only when idle) |
| seg_count_i | input | SEG_CNT_W | Number of segments in this build, sampled with start_i |
| seg_valid_i | input | 1 | Segment present |
| seg_ready_o | output | 1 | Segment accepted when high together with seg_valid_i |
| seg_addr_i | input | ADDR_W | Segment bus address |
| seg_len_i | input | LEN_W | Segment length in bytes (even) |
| mem_we_o | output | 1 | Table word write strobe |
| mem_addr_o | output | $clog2(2*DEPTH) | Table word address |
| mem_wdata_o | output | ADDR_W | Table word data |
| done_o | output | 1 | One-cycle build-complete pulse |
| fallback_o | output | 1 | Build failed (overflow or empty table) |
| entry_count_o | output | $clog2(DEPTH+1) | Descriptors built, 0 on fallback |

## Verification
The bench sweeps start offsets at and near the 64 KiB and 32 KiB marks against lengths of 2 bytes, exactly one span, a span plus 2 bytes and two spans. A design with an off-by-one in the room computation would produce descriptors straddling a boundary. A design without the half split would write a zero count field. Builds that need exactly `DEPTH` descriptors and one more are both run: a depth check placed after the write, or one that ignores the extra split half, would accept an overflowing table or reject a full one. Empty and all-zero-length builds check that no end marker lands on a phantom descriptor. A misplaced marker would set bit 31 on the wrong word or leave it set after a failed build.

// File: rtl/sgprd_pkg.sv
package sgprd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EMIT,
      ST_CNTW,
      ST_MARK,
      ST_DONE
   } sgprd_state_e;
endpackage

// File: rtl/sgprd_chunker.sv
module sgprd_chunker #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 32,
   parameter int SPAN_W = 16
) (
   input  logic [ADDR_W-1:0] cur_addr_i,
   input  logic [LEN_W-1:0]  remain_i,
   output logic [LEN_W-1:0]  emit_len_o
);
   localparam logic [LEN_W-1:0] SPAN = LEN_W'(1) << SPAN_W;
   localparam logic [LEN_W-1:0] HALF = LEN_W'(1) << (SPAN_W - 1);

   generate
      if (LEN_W <= SPAN_W) begin : g_bad_len
         $error("sgprd_chunker: LEN_W must exceed SPAN_W");
      end
   endgenerate

   logic [LEN_W-1:0] room;
   logic [LEN_W-1:0] chunk;

   always_comb begin
      room  = SPAN - LEN_W'(cur_addr_i[SPAN_W-1:0]);
      chunk = (remain_i < room) ? remain_i : room;
      // a whole span would leave an all-zero count field: take half now,
      // the next pass then lands exactly on the other half
      emit_len_o = (chunk == SPAN) ? HALF : chunk;
   end
endmodule

// File: rtl/sgprd_entry_ctr.sv
module sgprd_entry_ctr #(
   parameter int DEPTH = 256,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [CW-1:0] count_o,
   output logic          full_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_o <= '0;
      else if (clr_i) count_o <= '0;
      else if (inc_i) count_o <= count_o + CW'(1);
   end

   assign full_o = (count_o == CW'(DEPTH));
endmodule

// File: rtl/sgprd_builder.sv
module sgprd_builder #(
   parameter int DEPTH     = 256,
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 32,
   parameter int SPAN_W    = 16,
   parameter int SEG_CNT_W = 16,
   localparam int MAW      = $clog2(2 * DEPTH),
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [SEG_CNT_W-1:0] seg_count_i,
   input  logic                 seg_valid_i,
   output logic                 seg_ready_o,
   input  logic [ADDR_W-1:0]    seg_addr_i,
   input  logic [LEN_W-1:0]     seg_len_i,
   output logic                 mem_we_o,
   output logic [MAW-1:0]       mem_addr_o,
   output logic [ADDR_W-1:0]    mem_wdata_o,
   output logic                 done_o,
   output logic                 fallback_o,
   output logic [CW-1:0]        entry_count_o
);
   import sgprd_pkg::*;

   localparam int IW = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sgprd_builder: DEPTH must be at least 2");
      end
      if (ADDR_W <= SPAN_W) begin : g_bad_addr
         $error("sgprd_builder: ADDR_W must exceed SPAN_W so the end bit is free");
      end
      if (SEG_CNT_W < 1) begin : g_bad_seg
         $error("sgprd_builder: SEG_CNT_W must be positive");
      end
   endgenerate

   sgprd_state_e          state_q;
   logic [SEG_CNT_W-1:0]  segs_left_q;
   logic [ADDR_W-1:0]     cur_addr_q;
   logic [LEN_W-1:0]      remain_q;
   logic [LEN_W-1:0]      emit_len_q;
   logic [SPAN_W-1:0]     last_len_q;
   logic                  fb_q;
   logic [CW-1:0]         cnt_out_q;

   logic [LEN_W-1:0]      emit_len;
   logic [CW-1:0]         count;
   logic [CW-1:0]         count_m1;
   logic                  table_full;
   logic                  ctr_clr;
   logic                  ctr_inc;

   sgprd_chunker #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .SPAN_W (SPAN_W)
   ) u_chunk (
      .cur_addr_i (cur_addr_q),
      .remain_i   (remain_q),
      .emit_len_o (emit_len)
   );

   sgprd_entry_ctr #(
      .DEPTH (DEPTH)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (ctr_clr),
      .inc_i   (ctr_inc),
      .count_o (count),
      .full_o  (table_full)
   );

   assign ctr_clr  = (state_q == ST_IDLE) && start_i;
   assign ctr_inc  = (state_q == ST_CNTW);
   assign count_m1 = count - CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         segs_left_q <= '0;
         cur_addr_q  <= '0;
         remain_q    <= '0;
         emit_len_q  <= '0;
         last_len_q  <= '0;
         fb_q        <= 1'b0;
         cnt_out_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  segs_left_q <= seg_count_i;
                  remain_q    <= '0;
                  fb_q        <= 1'b0;
                  cnt_out_q   <= '0;
                  state_q     <= ST_EMIT;
               end
            end
            ST_FETCH: begin
               if (seg_valid_i) begin
                  cur_addr_q  <= seg_addr_i;
                  remain_q    <= seg_len_i;
                  segs_left_q <= segs_left_q - SEG_CNT_W'(1);
                  state_q     <= ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (remain_q == '0) begin
                  if (segs_left_q != '0) begin
                     state_q <= ST_FETCH;
                  end else if (count == '0) begin
                     fb_q    <= 1'b1;
                     state_q <= ST_DONE;
                  end else begin
                     state_q <= ST_MARK;
                  end
               end else if (table_full) begin
                  fb_q    <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  emit_len_q <= emit_len;
                  state_q    <= ST_CNTW;
               end
            end
            ST_CNTW: begin
               cur_addr_q <= cur_addr_q + ADDR_W'(emit_len_q);
               remain_q   <= remain_q - emit_len_q;
               last_len_q <= emit_len_q[SPAN_W-1:0];
               state_q    <= ST_EMIT;
            end
            ST_MARK: begin
               cnt_out_q <= count;
               state_q   <= ST_DONE;
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state_q)
         ST_EMIT: begin
            if ((remain_q != '0) && !table_full) begin
               mem_we_o    = 1'b1;
               mem_addr_o  = {count[IW-1:0], 1'b0};
               mem_wdata_o = cur_addr_q;
            end
         end
         ST_CNTW: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = {count[IW-1:0], 1'b1};
            mem_wdata_o = ADDR_W'(emit_len_q[SPAN_W-1:0]);
         end
         ST_MARK: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = {count_m1[IW-1:0], 1'b1};
            mem_wdata_o = {1'b1, (ADDR_W-1)'(last_len_q)};
         end
         default: ;
      endcase
   end

   assign seg_ready_o   = (state_q == ST_FETCH);
   assign done_o        = (state_q == ST_DONE);
   assign fallback_o    = fb_q;
   assign entry_count_o = cnt_out_q;
endmodule

// File: rtl/sgprd_builder_chk.sv
module sgprd_builder_chk #(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 32,
   parameter int MAW    = 9,
   parameter int CW     = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              seg_ready_o,
   input logic              mem_we_o,
   input logic [MAW-1:0]    mem_addr_o,
   input logic [ADDR_W-1:0] mem_wdata_o,
   input logic              done_o,
   input logic              fallback_o,
   input logic [CW-1:0]     entry_count_o
);
   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= 1'b0;
      else if (start_i) held_q <= 1'b0;
      else if (done_o)  held_q <= 1'b1;
   end

   p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      seg_ready_o |-> !mem_we_o);

   p_addr_in_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (int'(mem_addr_o) < 2 * DEPTH));

   p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && mem_addr_o[0]) |-> (mem_wdata_o[15:0] != 16'h0));

   p_marker_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && mem_addr_o[0] && mem_wdata_o[ADDR_W-1]) |=> (done_o && !fallback_o));

   p_fallback_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fallback_o) |-> (entry_count_o == '0));

   p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(entry_count_o) <= DEPTH));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !start_i) |=> ($stable(entry_count_o) && $stable(fallback_o)));
endmodule

bind sgprd_builder sgprd_builder_chk #(
   .DEPTH  (DEPTH),
   .ADDR_W (ADDR_W),
   .MAW    (MAW),
   .CW     (CW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .seg_ready_o   (seg_ready_o),
   .mem_we_o      (mem_we_o),
   .mem_addr_o    (mem_addr_o),
   .mem_wdata_o   (mem_wdata_o),
   .done_o        (done_o),
   .fallback_o    (fallback_o),
   .entry_count_o (entry_count_o)
);

// File: tb/sim_sgprd_builder.sv
module sim_sgprd_builder;
   localparam int DEPTH = 8;
   localparam int MAW   = $clog2(2 * DEPTH);
   localparam int CW    = $clog2(DEPTH + 1);
   localparam logic [31:0] SENT = 32'h5A5A_5A5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [15:0]   seg_count_i = '0;
   logic          seg_valid_i = 1'b0;
   logic          seg_ready_o;
   logic [31:0]   seg_addr_i = '0;
   logic [31:0]   seg_len_i = '0;
   logic          mem_we_o;
   logic [MAW-1:0] mem_addr_o;
   logic [31:0]   mem_wdata_o;
   logic          done_o;
   logic          fallback_o;
   logic [CW-1:0] entry_count_o;

   always #10 clk = ~clk;

   sgprd_builder #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .seg_count_i(seg_count_i),
      .seg_valid_i(seg_valid_i), .seg_ready_o(seg_ready_o),
      .seg_addr_i(seg_addr_i), .seg_len_i(seg_len_i),
      .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .done_o(done_o), .fallback_o(fallback_o), .entry_count_o(entry_count_o));

   int errors = 0;
   int checks = 0;

   logic [31:0] tbmem [0:2*DEPTH-1];
   int nwrites = 0;
   int hs = 0;
   int done_cycles = 0;
   bit done_seen = 1'b0;

   always @(posedge clk) begin
      if (mem_we_o) begin
         tbmem[mem_addr_o] <= mem_wdata_o;
         nwrites <= nwrites + 1;
      end
      if (seg_valid_i && seg_ready_o) hs <= hs + 1;
      if (done_o) begin
         done_seen   <= 1'b1;
         done_cycles <= done_cycles + 1;
      end
   end

   // segment list and expected table
   logic [31:0] sa [0:7];
   logic [31:0] sl [0:7];
   int nseg = 0;
   logic [31:0] ew [0:2*DEPTH-1];
   int en = 0;
   bit efb = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model();
      bit ovf = 1'b0;
      en = 0;
      for (int s = 0; s < nseg && !ovf; s++) begin
         longint a = sa[s];
         longint l = sl[s];
         while (l > 0 && !ovf) begin
            longint b = 64'h10000 - (a % 64'h10000);
            if (b > l) b = l;
            if (b == 64'h10000) begin
               if (en + 2 > DEPTH) ovf = 1'b1;
               else begin
                  ew[2*en] = a[31:0];   ew[2*en+1] = 32'h8000; en++;
                  ew[2*en] = a[31:0] + 32'h8000; ew[2*en+1] = 32'h8000; en++;
               end
            end else begin
               if (en + 1 > DEPTH) ovf = 1'b1;
               else begin
                  ew[2*en] = a[31:0]; ew[2*en+1] = 32'(b); en++;
               end
            end
            a = a + b;
            l = l - b;
         end
      end
      efb = ovf || (en == 0);
      if (!efb) ew[2*en-1] = ew[2*en-1] | 32'h8000_0000;
   endtask

   task automatic run_case(input string name);
      int t = 0;
      int hs0;
      int wr0;
      int dc0;
      for (int i = 0; i < 2*DEPTH; i++) tbmem[i] = SENT;
      model();
      @(negedge clk);
      done_seen = 1'b0;
      hs0 = hs; wr0 = nwrites; dc0 = done_cycles;
      start_i = 1'b1; seg_count_i = 16'(nseg);
      @(negedge clk);
      start_i = 1'b0;
      for (int s = 0; s < nseg; s++) begin
         if (done_seen) break;
         seg_valid_i = 1'b1; seg_addr_i = sa[s]; seg_len_i = sl[s];
         while (!seg_ready_o && !done_seen && t < 3000) begin
            @(negedge clk); t++;
         end
         if (done_seen) break;
         @(posedge clk);
         @(negedge clk);
         seg_valid_i = 1'b0;
      end
      seg_valid_i = 1'b0;
      while (!done_seen && t < 3000) begin @(negedge clk); t++; end
      chk(done_seen, "R9", {name, " done seen"}, done_seen, 1);
      chk(fallback_o == efb, efb ? "R7" : "R2", {name, " fallback"}, fallback_o, efb);
      chk(int'(entry_count_o) == (efb ? 0 : en), "R3", {name, " entry count"},
          entry_count_o, efb ? 0 : en);
      if (!efb) begin
         for (int i = 0; i < 2*en; i++)
            chk(tbmem[i] == ew[i], (i % 2) ? "R4" : "R2", {name, " table word"},
                tbmem[i], ew[i]);
         if (en < DEPTH)
            chk(tbmem[2*en] == SENT, "R6", {name, " past end untouched"}, tbmem[2*en], SENT);
         chk((hs - hs0) == nseg, "R10", {name, " segments accepted"}, hs - hs0, nseg);
      end else begin
         bit marked = 1'b0;
         for (int i = 1; i < 2*DEPTH; i += 2)
            if (tbmem[i] != SENT && tbmem[i][31]) marked = 1'b1;
         chk(!marked, "R7", {name, " no end marker on fallback"}, marked, 0);
      end
      repeat (3) @(negedge clk);
      chk((done_cycles - dc0) == 1, "R9", {name, " done one cycle"}, done_cycles - dc0, 1);
      chk(fallback_o == efb && int'(entry_count_o) == (efb ? 0 : en), "R9",
          {name, " result held"}, entry_count_o, efb ? 0 : en);
      if (nseg == 0 || efb && en == 0)
         chk(nwrites == wr0, "R8", {name, " no writes"}, nwrites - wr0, 0);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      automatic logic [31:0] offs [0:4] = '{32'h0, 32'h2, 32'h7FFE, 32'h8000, 32'hFFFE};
      automatic logic [31:0] lens [0:5] = '{32'h2, 32'h100, 32'h8000, 32'h10000, 32'h10002, 32'h20000};
      #1;
      chk(!done_o && !fallback_o && !mem_we_o && !seg_ready_o && entry_count_o == 0,
          "R1", "outputs in reset", {done_o, fallback_o, mem_we_o, seg_ready_o}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !fallback_o && !mem_we_o && !seg_ready_o && entry_count_o == 0,
          "R1", "outputs after reset", {done_o, fallback_o, mem_we_o, seg_ready_o}, 0);

      // R8: no segments at all
      nseg = 0;
      run_case("R8 empty list");
      // R5 R8: only a zero-length segment
      nseg = 1; sa[0] = 32'h0001_0000; sl[0] = 0;
      run_case("R5 zero length only");

      // R2 R3 R4: sweep offsets against lengths, single segment
      foreach (offs[o]) begin
         foreach (lens[l]) begin
            nseg = 1; sa[0] = 32'h1234_0000 + offs[o]; sl[0] = lens[l];
            run_case("R2 sweep");
         end
      end

      // R5: zero-length segment in the middle of a list
      nseg = 3;
      sa[0] = 32'h0000_FFF0; sl[0] = 32'h20;
      sa[1] = 32'h0040_0000; sl[1] = 32'h0;
      sa[2] = 32'h0050_8000; sl[2] = 32'h10000;
      run_case("R5 zero length mid list");

      // R7: exactly DEPTH entries fits, one more overflows
      nseg = 1; sa[0] = 32'h0100_0000; sl[0] = 32'h40000;
      run_case("R7 exact fit");
      nseg = 1; sa[0] = 32'h0100_0000; sl[0] = 32'h40002;
      run_case("R7 one over");
      // R7: overflow caused by the second half of a split
      nseg = 2; sa[0] = 32'h0200_0000; sl[0] = 32'h30000 + 32'h8000;
      sa[1] = 32'h0300_0000; sl[1] = 32'h10000;
      run_case("R7 split half over");

      // R6: many small segments, marker only on last
      nseg = 5;
      for (int i = 0; i < 5; i++) begin sa[i] = 32'h10 * i + 32'h9000_0000; sl[i] = 32'h4 + 2*i; end
      run_case("R6 small segments");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule